// File: doc/BRIEF.md
# Banked Host Register Window with Packet-Buffer Data Port

This block is the host-facing register window of a packet buffer controller. It occupies sixteen byte offsets. One of them holds a bank number that picks which of four register sets the other offsets reach. The bank-select byte and an identification byte stay visible in every bank. In the pointer bank, a 16-bit pointer and a four-byte data window turn host accesses into byte accesses to packet buffer memory. The memory is outside the block and has four byte lanes with a one-cycle read latency.

The pointer's top bit picks the page: the page at the head of the receive queue when set, or the page named by the packet-number register when clear. Both page numbers are inputs from the allocation logic. Bits 10:0 give the byte offset within the page. Bit 14 turns on auto-increment. With it set, consecutive data bytes come from consecutive offsets and the pointer moves past them. With it clear, the pointer stays fixed and the host's byte lane inside the window adds to the offset.

A host access of one, two or four bytes is split into byte operations at increasing offsets, placed little-endian. All its lanes are handled in the same cycle. A 32-bit write to offset 12 is trimmed so that only the bank-select and identification bytes are written. Read data returns one cycle after the request. Offsets with no defined meaning read as zero, ignore writes and raise a one-cycle error pulse.

Top module: `bw_host_window`

## Requirements
- R1: After synchronous reset the bank number is 0, the pointer is 0x0000, and host_rvalid and host_err are low.
- R2: Offset 14 reads the bank number (zero-extended) and a write to it loads the bank from bits 1:0 of its byte, in every bank. Offset 15 reads 0x33 in every bank. Writes to offset 15 are ignored without an error.
- R3: host_size 0, 1 and 2 (and 3) move 1, 2 and 4 bytes. Address bits below the access size are ignored. Lane k is offset base+k on bits 8k+7:8k. A read returns host_rdata with host_rvalid exactly one cycle later, and unused lanes read zero.
- R4: In bank 2, offset 6 is the low byte and offset 7 the high byte of the pointer. Reading offset 7 returns the high byte ANDed with 0xF7.
- R5: Bank 2 offsets 8 to 11 are the data window. Lane k drives mem_en[k] and mem_addr lane k = {page, 11-bit offset}. The page is rx_head_page when pointer bit 15 is set and pkt_page when it is clear. mem_we follows host_wr. No lane is enabled outside the window.
- R6: With pointer bit 14 clear, the byte offset is (pointer[10:0] + (offset AND 3)) mod 2048, and the pointer does not change.
- R7: With pointer bit 14 set, the k-th data byte of an access uses (pointer[10:0] + k) mod 2048. Afterwards pointer[10:0] advances by the number of bytes, wrapping at 2048, and bits 15:11 are unchanged.
- R8: A 32-bit write at offset 12 writes only offsets 14 and 15. Offsets 12 and 13 are untouched and raise no error.
- R9: Bank 0 offset 8 reads the page count NUM_PAGES. Bank 3 offset 10 reads the revision byte 0x91.
- R10: Any other lane reads zero and has no effect when written. So does a write to bank 0 offset 8 or bank 3 offset 10. host_err goes high for one cycle, one cycle after the access, when any active lane hit such an offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write request, one cycle |
| host_rd | input | 1 | Host read request, one cycle (ignored with host_wr) |
| host_addr | input | 4 | Byte offset within the window |
| host_size | input | 2 | Access size code: 0 byte, 1 half, 2/3 word |
| host_wdata | input | 32 | Write data, lane k on bits 8k+7:8k |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| host_err | output | 1 | Undefined-offset pulse, one cycle after the access |
| rx_head_page | input | PAGE_W | Page at the head of the receive queue |
| pkt_page | input | PAGE_W | Page held in the packet-number register |
| mem_en | output | 4 | Per-lane buffer memory enable |
| mem_we | output | 4 | Per-lane buffer memory write enable |
| mem_addr | output | 4*(PAGE_W+11) | Per-lane {page, byte offset} |
| mem_wdata | output | 32 | Per-lane write byte |
| mem_rdata | input | 32 | Per-lane read byte, one cycle after mem_en |

## Verification
The bench drives a 32-bit auto-increment write that starts at offset 0x7FE. It checks that the lane addresses wrap to 0x000 and that the pointer lands on 0x002 with its high bits kept. A design that carried into bit 11 would corrupt the page-select field. A trimmed word write at offset 12 is checked next to an untrimmed half-word write there. If the trim were missing, the bench would see an error pulse; if it were applied to every size, the half-word case would lose its error. Fixed-pointer reads at odd lanes and misaligned half-word addresses expose a design that adds the wrong lane offset or does not clear the low address bits. Reads of the pointer high byte with bit 11 set catch a missing 0xF7 mask.

// File: rtl/bw_pkg.sv
// Shared constants and lane classification type for the banked host window.
// Assumes a 16-byte window and four-byte host data path.
package bw_pkg;
    localparam int LANES   = 4;
    localparam int OFS_W   = 11;
    localparam int PSEL_BIT = 15;
    localparam int AUTO_BIT = 14;

    localparam logic [3:0] A_BANK = 4'd14;
    localparam logic [3:0] A_ID   = 4'd15;
    localparam logic [3:0] A_PCNT = 4'd8;
    localparam logic [3:0] A_REV  = 4'd10;
    localparam logic [3:0] A_PLO  = 4'd6;
    localparam logic [3:0] A_PHI  = 4'd7;
    localparam logic [3:0] A_TRIM = 4'd12;

    localparam logic [1:0] BK_CNT = 2'd0;
    localparam logic [1:0] BK_PTR = 2'd2;
    localparam logic [1:0] BK_REV = 2'd3;

    localparam logic [7:0] ID_BYTE  = 8'h33;
    localparam logic [7:0] REV_BYTE = 8'h91;
    localparam logic [7:0] PHI_MASK = 8'hF7;

    typedef enum logic [3:0] {
        LK_OFF, LK_BANK, LK_ID, LK_IGN, LK_PCNT,
        LK_REV, LK_PLO, LK_PHI, LK_DATA, LK_BAD
    } lane_kind_t;
endpackage

// File: rtl/bw_lane_dec.sv
// Classifies one byte lane of a host access by bank, offset and direction.
// Assumes the caller has already applied size and trim gating to 'active'.
module bw_lane_dec
    import bw_pkg::*;
(
    input  logic       active,
    input  logic       is_wr,
    input  logic [1:0] bank,
    input  logic [3:0] ofs,
    output lane_kind_t kind
);
    // Offset decode, bank-independent offsets first.
    always_comb begin
        kind = LK_BAD;
        if (!active)                                   kind = LK_OFF;
        else if (ofs == A_BANK)                        kind = LK_BANK;
        else if (ofs == A_ID)                          kind = is_wr ? LK_IGN : LK_ID;
        else if (bank == BK_CNT && ofs == A_PCNT && !is_wr) kind = LK_PCNT;
        else if (bank == BK_REV && ofs == A_REV && !is_wr)  kind = LK_REV;
        else if (bank == BK_PTR && ofs == A_PLO)       kind = LK_PLO;
        else if (bank == BK_PTR && ofs == A_PHI)       kind = LK_PHI;
        else if (bank == BK_PTR && ofs[3:2] == 2'b10)  kind = LK_DATA;
    end
endmodule

// File: rtl/bw_ptr.sv
// Holds the 16-bit buffer pointer and forms a {page, offset} address per lane.
// Assumes pointer writes and data-window steps never occur in the same access.
module bw_ptr
    import bw_pkg::*;
#(
    parameter int PAGE_W = 2,
    localparam int AW = PAGE_W + OFS_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_lo,
    input  logic                   wr_hi,
    input  logic [7:0]             lo_val,
    input  logic [7:0]             hi_val,
    input  logic                   step,
    input  logic [2:0]             step_n,
    input  logic [LANES-1:0][1:0]  lane_lo,
    input  logic [PAGE_W-1:0]      rx_page,
    input  logic [PAGE_W-1:0]      pk_page,
    output logic [15:0]            ptr_q,
    output logic [LANES*AW-1:0]    lane_addr
);
    logic [PAGE_W-1:0] page;

    // Pointer register: byte writes and wrapping offset advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            if (wr_lo) ptr_q[7:0]  <= lo_val;
            if (wr_hi) ptr_q[15:8] <= hi_val;
            if (step)  ptr_q[OFS_W-1:0] <= ptr_q[OFS_W-1:0] + OFS_W'(step_n);
        end
    end

    // Page select from the pointer's top bit.
    always_comb page = ptr_q[PSEL_BIT] ? rx_page : pk_page;

    for (genvar k = 0; k < LANES; k++) begin : g_addr
        logic [OFS_W-1:0] adj;
        // Offset step: data-byte index when auto-incrementing, else window lane.
        always_comb adj = ptr_q[AUTO_BIT] ? OFS_W'(k) : OFS_W'(lane_lo[k]);
        assign lane_addr[k*AW +: AW] = {page, ptr_q[OFS_W-1:0] + adj};
    end
endmodule

// File: rtl/bw_rd_ret.sv
// Captures per-lane read sources and assembles host read data one cycle later.
// Assumes buffer memory returns read bytes exactly one cycle after enable.
module bw_rd_ret
    import bw_pkg::*;
#(
    parameter int NUM_PAGES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_go,
    input  lane_kind_t [LANES-1:0] kind,
    input  logic [1:0]            bank,
    input  logic [15:0]           ptr,
    input  logic [31:0]           mem_rdata,
    output logic [31:0]           rdata,
    output logic                  rvalid
);
    logic [31:0]      const_d, const_q;
    logic [LANES-1:0] mem_d, mem_q;

    // Per-lane constant byte or memory-source flag.
    always_comb begin
        const_d = '0;
        mem_d   = '0;
        for (int k = 0; k < LANES; k++) begin
            case (kind[k])
                LK_BANK: const_d[8*k +: 8] = {6'd0, bank};
                LK_ID:   const_d[8*k +: 8] = ID_BYTE;
                LK_PCNT: const_d[8*k +: 8] = 8'(NUM_PAGES);
                LK_REV:  const_d[8*k +: 8] = REV_BYTE;
                LK_PLO:  const_d[8*k +: 8] = ptr[7:0];
                LK_PHI:  const_d[8*k +: 8] = ptr[15:8] & PHI_MASK;
                LK_DATA: mem_d[k] = 1'b1;
                default: ;
            endcase
        end
    end

    // Return-stage registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid  <= 1'b0;
            const_q <= '0;
            mem_q   <= '0;
        end else begin
            rvalid <= rd_go;
            if (rd_go) begin
                const_q <= const_d;
                mem_q   <= mem_d;
            end
        end
    end

    // Lane merge of constants and memory bytes.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < LANES; k++)
            rdata[8*k +: 8] = !rvalid ? 8'd0 : (mem_q[k] ? mem_rdata[8*k +: 8] : const_q[8*k +: 8]);
    end
endmodule

// File: rtl/bw_host_window.sv
// Banked 16-byte host register window with a pointer-driven packet-buffer data port.
// Splits each aligned 1/2/4-byte access into per-lane byte operations in one cycle.
// Assumes host_wr and host_rd are single-cycle pulses; a write wins over a read.
module bw_host_window
    import bw_pkg::*;
#(
    parameter int PAGE_W    = 2,
    parameter int NUM_PAGES = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              host_wr,
    input  logic                              host_rd,
    input  logic [3:0]                        host_addr,
    input  logic [1:0]                        host_size,
    input  logic [31:0]                       host_wdata,
    output logic [31:0]                       host_rdata,
    output logic                              host_rvalid,
    output logic                              host_err,
    input  logic [PAGE_W-1:0]                 rx_head_page,
    input  logic [PAGE_W-1:0]                 pkt_page,
    output logic [LANES-1:0]                  mem_en,
    output logic [LANES-1:0]                  mem_we,
    output logic [LANES*(PAGE_W+OFS_W)-1:0]   mem_addr,
    output logic [31:0]                       mem_wdata,
    input  logic [31:0]                       mem_rdata
);
    logic                  go, trim, rd_go;
    logic [2:0]            nbytes;
    logic [3:0]            base;
    logic [1:0]            bank_q, bank_val;
    logic                  bank_wr, data_hit, bad_hit, err_q;
    logic                  wr_lo, wr_hi;
    logic [7:0]            lo_val, hi_val;
    logic [15:0]           ptr_q;
    logic [LANES-1:0][1:0] lane_lo;
    lane_kind_t [LANES-1:0] kind;

    // Access size, aligned base offset and word-write trim.
    always_comb begin
        go     = host_wr | host_rd;
        rd_go  = host_rd & ~host_wr;
        case (host_size)
            2'd0:    nbytes = 3'd1;
            2'd1:    nbytes = 3'd2;
            default: nbytes = 3'd4;
        endcase
        base = host_addr & ~(4'(nbytes) - 4'd1);
        trim = host_wr && nbytes == 3'd4 && base == A_TRIM;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [3:0] ofs;
        logic       act;
        assign ofs = base + 4'(k);
        assign act = go && (k < int'(nbytes)) && !(trim && k < 2);
        bw_lane_dec u_dec (
            .active (act),
            .is_wr  (host_wr),
            .bank   (bank_q),
            .ofs    (ofs),
            .kind   (kind[k])
        );
        assign lane_lo[k] = ofs[1:0];
        assign mem_en[k]  = (kind[k] == LK_DATA);
        assign mem_we[k]  = (kind[k] == LK_DATA) && host_wr;
    end

    assign mem_wdata = host_wdata;

    // Gather register write requests and hit flags across lanes.
    always_comb begin
        wr_lo = 1'b0; wr_hi = 1'b0; lo_val = '0; hi_val = '0;
        bank_wr = 1'b0; bank_val = bank_q; data_hit = 1'b0; bad_hit = 1'b0;
        for (int k = 0; k < LANES; k++) begin
            case (kind[k])
                LK_BANK: if (host_wr) begin bank_wr = 1'b1; bank_val = host_wdata[8*k +: 2]; end
                LK_PLO:  if (host_wr) begin wr_lo = 1'b1; lo_val = host_wdata[8*k +: 8]; end
                LK_PHI:  if (host_wr) begin wr_hi = 1'b1; hi_val = host_wdata[8*k +: 8]; end
                LK_DATA: data_hit = 1'b1;
                LK_BAD:  bad_hit = 1'b1;
                default: ;
            endcase
        end
    end

    // Bank register and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (bank_wr) bank_q <= bank_val;
            err_q <= bad_hit;
        end
    end
    assign host_err = err_q;

    bw_ptr #(.PAGE_W(PAGE_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .lo_val    (lo_val),
        .hi_val    (hi_val),
        .step      (data_hit && ptr_q[AUTO_BIT]),
        .step_n    (nbytes),
        .lane_lo   (lane_lo),
        .rx_page   (rx_head_page),
        .pk_page   (pkt_page),
        .ptr_q     (ptr_q),
        .lane_addr (mem_addr)
    );

    bw_rd_ret #(.NUM_PAGES(NUM_PAGES)) u_ret (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_go     (rd_go),
        .kind      (kind),
        .bank      (bank_q),
        .ptr       (ptr_q),
        .mem_rdata (mem_rdata),
        .rdata     (host_rdata),
        .rvalid    (host_rvalid)
    );
endmodule

// File: rtl/bw_host_window_chk.sv
// Protocol checker for bw_host_window, attached by bind below.
// Assumes access to the bank and pointer state through the bind connection.
module bw_host_window_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr,
    input logic        host_rd,
    input logic        host_rvalid,
    input logic        host_err,
    input logic [3:0]  mem_en,
    input logic [3:0]  mem_we,
    input logic [1:0]  bank_q,
    input logic [15:0] ptr_q
);
    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr) |=> host_rvalid); // R3
    AST_NO_RVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd && !host_wr) |=> !host_rvalid); // R3
    AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr || host_rd) |=> !host_err); // R10
    AST_MEM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr || host_rd) |-> (mem_en == 4'd0)); // R5
    AST_WE_WITHIN_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we & ~mem_en) == 4'd0); // R5
    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> $stable(bank_q)); // R2
    AST_PTR_FIXED_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr && !ptr_q[14]) |=> $stable(ptr_q)); // R6
endmodule

bind bw_host_window bw_host_window_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_rvalid (host_rvalid),
    .host_err    (host_err),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .bank_q      (bank_q),
    .ptr_q       (ptr_q)
);

// File: tb/sim_bw_host_window.sv
// Self-checking bench: behavioural reference model of the window, compared per access and idle cycle.
module sim_bw_host_window;
    localparam int PW = 2;
    localparam int NP = 4;
    localparam int AW = PW + 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_rvalid, host_err;
    logic [PW-1:0] rxp = '0, pkp = '0;
    logic [3:0]  mem_en, mem_we;
    logic [4*AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    logic [7:0] dut_mem [0:NP*2048-1];
    logic [7:0] ref_mem [0:NP*2048-1];

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    int m_bank = 0;
    logic [15:0] m_ptr = '0;

    always #5 clk = ~clk;

    bw_host_window #(.PAGE_W(PW), .NUM_PAGES(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid), .host_err(host_err),
        .rx_head_page(rxp), .pkt_page(pkp), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // External buffer memory: one-cycle read, per-lane write.
    always @(posedge clk) begin
        for (int k = 0; k < 4; k++) begin
            if (mem_en[k]) begin
                if (mem_we[k]) dut_mem[mem_addr[k*AW +: AW]] <= mem_wdata[8*k +: 8];
                else           mem_rdata[8*k +: 8] <= dut_mem[mem_addr[k*AW +: AW]];
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // One host access against the reference model.
    task automatic acc(input bit wr, input logic [3:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, input string req);
        int nb, base, ndata;
        logic [31:0] erd;
        bit eerr;
        logic [3:0] een;
        logic [AW-1:0] eaddr [4];
        logic [15:0] nptr;
        int nbank;
        nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        base = int'(a) & ~(nb - 1);
        erd = '0; eerr = 0; een = '0; ndata = 0;
        nptr = m_ptr; nbank = m_bank;
        for (int k = 0; k < 4; k++) eaddr[k] = '0;
        for (int k = 0; k < nb; k++) begin
            int o;
            logic [7:0] b;
            o = base + k;
            b = wd[8*k +: 8];
            if (wr && nb == 4 && base == 12 && k < 2) continue;
            if (o == 14) begin
                if (wr) nbank = int'(b[1:0]); else erd[8*k +: 8] = 8'(m_bank);
            end else if (o == 15) begin
                if (!wr) erd[8*k +: 8] = 8'h33;
            end else if (m_bank == 0 && o == 8 && !wr) erd[8*k +: 8] = 8'(NP);
            else if (m_bank == 3 && o == 10 && !wr) erd[8*k +: 8] = 8'h91;
            else if (m_bank == 2 && o == 6) begin
                if (wr) nptr[7:0] = b; else erd[8*k +: 8] = m_ptr[7:0];
            end else if (m_bank == 2 && o == 7) begin
                if (wr) nptr[15:8] = b; else erd[8*k +: 8] = m_ptr[15:8] & 8'hF7;
            end else if (m_bank == 2 && o >= 8 && o <= 11) begin
                int bo, pg, ad;
                bo = m_ptr[14] ? (int'(m_ptr[10:0]) + ndata) % 2048
                               : (int'(m_ptr[10:0]) + (o % 4)) % 2048;
                pg = m_ptr[15] ? int'(rxp) : int'(pkp);
                ad = pg * 2048 + bo;
                een[k] = 1'b1;
                eaddr[k] = AW'(ad);
                if (wr) ref_mem[ad] = b; else erd[8*k +: 8] = ref_mem[ad];
                ndata++;
            end else eerr = 1;
        end
        if (m_ptr[14] && ndata > 0) nptr[10:0] = m_ptr[10:0] + 11'(ndata);

        @(negedge clk);
        host_wr = wr; host_rd = !wr; host_addr = a; host_size = sz; host_wdata = wd;
        #1;
        chk({req, " mem_en"}, {28'd0, mem_en}, {28'd0, een});
        chk({req, " mem_we"}, {28'd0, mem_we}, {28'd0, wr ? een : 4'd0});
        for (int k = 0; k < 4; k++)
            if (een[k]) chk({req, " mem_addr"}, 32'(mem_addr[k*AW +: AW]), 32'(eaddr[k]));
        @(negedge clk);
        chk({req, " rvalid"}, {31'd0, host_rvalid}, {31'd0, !wr});
        if (!wr) chk({req, " rdata"}, host_rdata, erd);
        chk({req, " err"}, {31'd0, host_err}, {31'd0, eerr});
        host_wr = 0; host_rd = 0;
        m_bank = nbank; m_ptr = nptr;
    endtask

    task automatic idle_chk(input string req);
        @(negedge clk);
        chk({req, " idle rvalid"}, {31'd0, host_rvalid}, 32'd0);
        chk({req, " idle err"}, {31'd0, host_err}, 32'd0);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NP * 2048; i++) begin
            dut_mem[i] = 8'(i * 7 + 3);
            ref_mem[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rvalid", {31'd0, host_rvalid}, 32'd0);
        chk("R1 err", {31'd0, host_err}, 32'd0);
        rst_n = 1'b1;
        acc(0, 4'd14, 2'd0, 0, "R1 bank");
        // R2 bank select and id byte
        acc(1, 4'd14, 2'd0, 32'hFE, "R2 bank write");
        acc(0, 4'd14, 2'd0, 0, "R2 bank read");
        acc(0, 4'd6, 2'd1, 0, "R1 pointer reset");
        acc(1, 4'd15, 2'd0, 32'h55, "R2 id write ignored");
        acc(0, 4'd15, 2'd0, 0, "R2 id read");
        idle_chk("R3");
        // R9 fixed reads, R10 undefined lanes
        acc(1, 4'd14, 2'd0, 32'h0, "R2 select bank0");
        acc(0, 4'd8, 2'd0, 0, "R9 page count");
        acc(1, 4'd8, 2'd0, 32'h77, "R10 write read-only count");
        acc(1, 4'd14, 2'd0, 32'h3, "R2 select bank3");
        acc(0, 4'd10, 2'd0, 0, "R9 revision");
        acc(0, 4'd8, 2'd2, 0, "R10 word read with undefined lanes");
        acc(1, 4'd10, 2'd0, 32'h12, "R10 write read-only revision");
        acc(0, 4'd10, 2'd0, 0, "R10 revision unchanged");
        acc(1, 4'd14, 2'd0, 32'h1, "R2 select bank1");
        acc(0, 4'd0, 2'd1, 0, "R10 undefined read");
        idle_chk("R10");
        // R4 pointer bytes and high-byte mask
        acc(1, 4'd14, 2'd0, 32'h2, "R2 select bank2");
        acc(1, 4'd6, 2'd1, 32'hC805, "R4 pointer write");
        acc(0, 4'd7, 2'd0, 0, "R4 pointer high masked");
        acc(0, 4'd6, 2'd0, 0, "R4 pointer low");
        acc(1, 4'd7, 2'd0, 32'h0F, "R4 pointer high write");
        acc(0, 4'd6, 2'd1, 0, "R4 bit 11 masked");
        // R5 R6 fixed pointer, packet-number page
        pkp = 2'd1; rxp = 2'd3;
        acc(1, 4'd6, 2'd1, 32'h0010, "R6 pointer fixed");
        acc(1, 4'd8, 2'd2, 32'hA1B2C3D4, "R5 word write");
        acc(0, 4'd9, 2'd0, 0, "R6 odd lane read");
        acc(0, 4'd11, 2'd1, 0, "R3 misaligned half");
        acc(0, 4'd6, 2'd1, 0, "R6 pointer unchanged");
        // R5 receive-head page
        acc(1, 4'd7, 2'd0, 32'h80, "R5 select rx page");
        acc(0, 4'd8, 2'd2, 0, "R5 rx page read");
        // R7 auto-increment with wrap
        pkp = 2'd2;
        acc(1, 4'd6, 2'd1, 32'h47FE, "R7 pointer auto");
        acc(1, 4'd8, 2'd2, 32'h11223344, "R7 wrap write");
        acc(0, 4'd6, 2'd1, 0, "R7 pointer advanced");
        acc(1, 4'd6, 2'd1, 32'h47FE, "R7 pointer rewind");
        acc(0, 4'd8, 2'd2, 0, "R7 wrap read");
        acc(0, 4'd10, 2'd1, 0, "R7 half read");
        acc(0, 4'd9, 2'd0, 0, "R7 byte read");
        acc(0, 4'd6, 2'd1, 0, "R7 pointer after reads");
        // R8 word write trim vs half write at 12
        acc(1, 4'd12, 2'd1, 32'hBEEF, "R8 half write at 12 not trimmed");
        acc(1, 4'd12, 2'd2, 32'h5503BEEF, "R8 trimmed word write");
        acc(0, 4'd14, 2'd0, 0, "R8 bank after trim");
        acc(0, 4'd12, 2'd2, 0, "R8 word read at 12");
        idle_chk("R3");
        finish_run();
    end
endmodule